// File: doc/BRIEF.md
# Vector predicate result bit packer

This unit collects a stream of per-element condition test results and packs them into integer destination elements. Each result arrives on its own cycle, in element order from 0 to VL-1. A result is either a single bit or a four-bit group. The packer fills one destination element at a time and hands it out together with its register offset, which is counted from the first destination register. Bits of an element that hold no result are zero.

How many results share a destination element is chosen by a two-bit source-width code, not by the destination width. For four-bit results a two-bit destination-width code limits the group size, so groups that do not fit spill over into the following elements. In scalar-destination mode every result goes into one register, at a position given by its element index. A one-cycle start pulse loads the configuration and the vector length and clears the accumulator. Both the input and the output use a valid/ready handshake. A one-cycle done pulse follows the transfer of the final element.

Top module: `vpred_packer`

## Requirements
- R1: After reset, out_valid, in_ready and done are all 0.
- R2: With single-bit results (cfg_nibble=0) and a vector destination (cfg_scalar=0), cfg_src codes 00/01/10/11 pack 1/2/4/8 results per destination element. Result i is taken from in_res[0]; in_res[3:1] are ignored. It lands in bit (i mod count), counted from the LSB, of the element with out_offset i/count.
- R3: Every bit of out_data at or above count × result width is 0.
- R4: With single-bit results and cfg_scalar=1, result i lands in bit i of a single element at out_offset 0 (VL up to 64).
- R5: With four-bit results and a vector destination, cfg_dst codes 00/01/10/11 stand for widths of 64/8/16/32 bits. For half = width/2, cfg_src codes 00/01/10/11 give a count of 1, 2, min(4,half) and min(8,half). Result i goes to nibble slot b = i mod count, at out_data[4b+3:4b], in the element with out_offset i/count. in_res[3] is the first test of the group.
- R6: With four-bit results and cfg_scalar=1, result i goes to nibble slot i of a single element at out_offset 0. VL must not exceed 16; beyond that the output is undefined.
- R7: When the last result arrives in a partly filled element, that element is still emitted, with its empty slots at zero.
- R8: While out_valid=1 and out_ready=0, out_data and out_offset hold and out_valid stays high.
- R9: After VL results have been accepted, in_ready stays 0. done is high for exactly one cycle, the cycle after the final element is transferred.
- R10: A start pulse while idle begins a fresh run: the accumulator is cleared and offsets count again from 0. A start pulse during a run has no effect on its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; loads the configuration and the length |
| cfg_nibble | input | 1 | 1: four-bit results, 0: single-bit results |
| cfg_scalar | input | 1 | 1: scalar destination, all results in one register |
| cfg_src | input | 2 | Source-width code selecting the packing density |
| cfg_dst | input | 2 | Destination-width code capping four-bit packing |
| vec_len | input | LEN_W | Number of results in the run (VL) |
| in_valid | input | 1 | A result is offered |
| in_ready | output | 1 | The packer takes the offered result |
| in_res | input | 4 | Result; bit 0 only for single-bit results |
| out_valid | output | 1 | A completed destination element is offered |
| out_ready | input | 1 | The consumer takes the element |
| out_data | output | DATA_W | Packed destination element |
| out_offset | output | LEN_W | Register offset of the element |
| done | output | 1 | One-cycle pulse after the final element is transferred |

## Verification
The assertions take for granted that the configuration inputs only matter in the cycle of an idle start. They also take for granted that a scalar run never asks for more results than one register holds: at most 64 single bits, or 16 nibbles. The stimulus keeps every scalar run within those limits. It changes the configuration inputs and pulses start in the middle of one run, to show that the run in progress is unaffected. Random stalls on both handshakes exercise the rule that the output holds under back-pressure, and the bench's own queue of expected elements is built from the packing rules alone.

// File: rtl/vpred_pack_pkg.sv
package vpred_pack_pkg;

  typedef struct packed {
    logic       nibble;
    logic       scalar;
    logic [1:0] src_code;
    logic [1:0] dst_code;
  } pack_mode_t;

  // destination element width in bits selected by the destination code
  function automatic int dest_span(logic [1:0] code);
    case (code)
      2'b01:   return 8;
      2'b10:   return 16;
      2'b11:   return 32;
      default: return 64;
    endcase
  endfunction

  function automatic int lane_bits(logic nibble);
    return nibble ? 4 : 1;
  endfunction

  // how many results share one destination element
  function automatic int group_size(pack_mode_t m, int data_w);
    int half;
    half = dest_span(m.dst_code) / 2;
    if (m.scalar) return data_w / lane_bits(m.nibble);
    if (!m.nibble) return 1 << m.src_code;
    case (m.src_code)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return (half < 4) ? half : 4;
      default: return (half < 8) ? half : 8;
    endcase
  endfunction

endpackage

// File: rtl/vpred_mode_decode.sv
module vpred_mode_decode
  import vpred_pack_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input  pack_mode_t          mode,
  output logic [CNT_W-1:0]    group,
  output logic [DATA_W-1:0]   used_mask
);

  int span_bits;

  always_comb begin
    group     = CNT_W'(group_size(mode, DATA_W));
    span_bits = int'(group) * lane_bits(mode.nibble);
    for (int k = 0; k < DATA_W; k++) begin
      used_mask[k] = (k < span_bits);
    end
  end

endmodule

// File: rtl/vpred_lane_accum.sv
module vpred_lane_accum #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic              flush,
  input  logic              nibble,
  input  logic [3:0]        res,
  input  logic [CNT_W-1:0]  group,
  output logic              slot_full,
  output logic [DATA_W-1:0] merged
);

  logic [CNT_W-1:0]  slot_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] placed;

  // drop the incoming result into its slot
  always_comb begin
    for (int k = 0; k < DATA_W; k++) begin
      if (nibble) placed[k] = ((k / 4) == int'(slot_q)) ? res[k % 4] : 1'b0;
      else        placed[k] = (k == int'(slot_q)) ? res[0] : 1'b0;
    end
  end

  assign merged    = acc_q | placed;
  assign slot_full = (slot_q == group - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      acc_q  <= '0;
    end else if (clear || (push && flush)) begin
      slot_q <= '0;
      acc_q  <= '0;
    end else if (push) begin
      slot_q <= slot_q + CNT_W'(1);
      acc_q  <= merged;
    end
  end

  // R5: the fill position never leaves the current group
  assert_slot_in_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < group);

endmodule

// File: rtl/vpred_packer.sv
module vpred_packer
  import vpred_pack_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 8,
  localparam int CNT_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_nibble,
  input  logic              cfg_scalar,
  input  logic [1:0]        cfg_src,
  input  logic [1:0]        cfg_dst,
  input  logic [LEN_W-1:0]  vec_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_res,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [LEN_W-1:0]  out_offset,
  output logic              done
);

  pack_mode_t        mode_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  idx_q;
  logic [LEN_W-1:0]  off_q;
  logic              busy_q;
  logic              out_valid_q;
  logic [DATA_W-1:0] out_data_q;
  logic [LEN_W-1:0]  out_off_q;
  logic              out_last_q;
  logic              done_q;

  logic [CNT_W-1:0]  group;
  logic [DATA_W-1:0] used_mask;
  logic              slot_full;
  logic [DATA_W-1:0] merged;

  // named internal events
  logic start_ok;
  logic all_in;
  logic last_in;
  logic accept;
  logic out_fire;
  logic flush;

  assign start_ok = start && !busy_q;
  assign all_in   = (idx_q == len_q);
  assign last_in  = ((LEN_W+1)'(idx_q) + (LEN_W+1)'(1)) == (LEN_W+1)'(len_q);
  assign out_fire = out_valid_q && out_ready;
  assign in_ready = busy_q && !all_in && (!out_valid_q || out_ready);
  assign accept   = in_valid && in_ready;
  assign flush    = accept && (slot_full || last_in);

  vpred_mode_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_decode (
    .mode      (mode_q),
    .group     (group),
    .used_mask (used_mask)
  );

  vpred_lane_accum #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_ok),
    .push      (accept),
    .flush     (flush),
    .nibble    (mode_q.nibble),
    .res       (in_res),
    .group     (group),
    .slot_full (slot_full),
    .merged    (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= '0;
      len_q       <= '0;
      idx_q       <= '0;
      off_q       <= '0;
      busy_q      <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_off_q   <= '0;
      out_last_q  <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        mode_q <= '{nibble: cfg_nibble, scalar: cfg_scalar,
                    src_code: cfg_src, dst_code: cfg_dst};
        len_q  <= vec_len;
        idx_q  <= '0;
        off_q  <= '0;
        busy_q <= (vec_len != '0);
        done_q <= (vec_len == '0);
      end else begin
        if (accept) idx_q <= idx_q + LEN_W'(1);
        if (out_fire) begin
          out_valid_q <= 1'b0;
          if (out_last_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
        if (flush) begin
          off_q       <= off_q + LEN_W'(1);
          out_valid_q <= 1'b1;
          out_data_q  <= merged;
          out_off_q   <= off_q;
          out_last_q  <= last_in;
        end
      end
    end
  end

  assign out_valid  = out_valid_q;
  assign out_data   = out_data_q;
  assign out_offset = out_off_q;
  assign done       = done_q;

  // R8: a stalled element holds still
  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_offset)));

  // R3: nothing outside the group's bit span
  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data & ~used_mask) == '0));

  // R9: done is a single-cycle pulse
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: final transfer is followed by done
  assert_done_follows_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last_q) |=> done);

  // R9: no result taken once the run is idle
  assert_idle_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !in_ready);

endmodule

// File: tb/test_vpred_packer.sv
module test_vpred_packer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_nibble = 1'b0;
  logic        cfg_scalar = 1'b0;
  logic [1:0]  cfg_src = 2'b00;
  logic [1:0]  cfg_dst = 2'b00;
  logic [7:0]  vec_len = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_res = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;
  logic [7:0]  out_offset;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [3:0]  res_arr [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  vpred_packer i_vpred_packer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_nibble(cfg_nibble), .cfg_scalar(cfg_scalar),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .vec_len(vec_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_res(in_res),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_offset(out_offset), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int per_element(bit nib, bit scal, logic [1:0] src, logic [1:0] dst);
    int span, half;
    if (scal) return nib ? 16 : 64;
    if (!nib) return 1 << src;
    span = (dst == 2'b00) ? 64 : (4 << dst);
    half = span / 2;
    if (src == 2'b00) return 1;
    if (src == 2'b01) return 2;
    if (src == 2'b10) return (half < 4) ? half : 4;
    return (half < 8) ? half : 8;
  endfunction

  task automatic run_case(input bit nib, input bit scal, input logic [1:0] src,
                          input logic [1:0] dst, input int len, input int seed,
                          input bit rdy_always, input bit poke, input string tag);
    int cnt, w, nout, oi, ii, guard;
    bit pend_done, seen_done, hold, poked, fin;
    logic [63:0] hd, val;
    logic [7:0]  ho;
    logic [63:0] exp_q[$];
    string rt;
    cnt = per_element(nib, scal, src, dst);
    w = nib ? 4 : 1;
    nout = (len + cnt - 1) / cnt;
    for (int i = 0; i < len; i++)
      res_arr[i] = 4'((i * 5 + seed + (i >> 3) * 3) ^ (seed >> 1));
    for (int o = 0; o < nout; o++) begin
      val = '0;
      for (int s = 0; s < cnt; s++) begin
        int i;
        i = o * cnt + s;
        if (i < len) val = val | (64'(nib ? res_arr[i] : {3'b0, res_arr[i][0]}) << (s * w));
      end
      exp_q.push_back(val);
    end
    @(negedge clk);
    cfg_nibble = nib; cfg_scalar = scal; cfg_src = src; cfg_dst = dst;
    vec_len = 8'(len); start = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    oi = 0; ii = 0; guard = 0;
    pend_done = 0; seen_done = 0; hold = 0; poked = 0;
    while (!seen_done && guard < 5000) begin
      guard++;
      // registered outputs, sampled away from the edge
      check(done === pend_done, "R9 done timing", 64'(done), 64'(pend_done));
      if (done) seen_done = 1;
      pend_done = 0;
      if (hold) check(out_valid === 1'b1 && out_data === hd && out_offset === ho,
                      "R8 stall hold", out_data, hd);
      // drive
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid = (ii < len) && (lfsr[0] | lfsr[3]);
      in_res = (ii < len) ? res_arr[ii] : 4'h0;
      out_ready = rdy_always | lfsr[5];
      start = 1'b0;
      if (poke && ii == 2 && !poked) begin
        poked = 1;
        start = 1'b1; cfg_nibble = ~nib; cfg_scalar = ~scal; cfg_src = ~src;
        vec_len = 8'd3;
      end
      #1;
      fin = 0;
      if (out_valid && out_ready) begin
        if (oi < nout) begin
          rt = (oi == nout - 1 && (len % cnt) != 0) ? "R7 partial last" : tag;
          check(out_data === exp_q[oi] && out_offset === 8'(oi), rt, out_data, exp_q[oi]);
          if (oi == 0) check(out_offset === 8'd0, "R10 offset restarts", 64'(out_offset), 64'd0);
          if (cnt * w < 64) check((out_data >> (cnt * w)) == 64'd0, "R3 unused bits", out_data, 64'd0);
          if (oi == nout - 1) fin = 1;
        end else begin
          check(1'b0, "R9 extra element", out_data, 64'd0);
        end
        oi++;
      end
      if (ii >= len) check(in_ready === 1'b0, "R9 no accept after VL", 64'(in_ready), 64'd0);
      if (in_valid && in_ready) ii++;
      hold = out_valid && !out_ready;
      hd = out_data; ho = out_offset;
      pend_done = fin;
      @(negedge clk);
    end
    check(oi == nout && seen_done, {tag, " run complete"}, 64'(oi), 64'(nout));
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        finished = 1;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b0 && done === 1'b0, "R1 reset state",
          {61'd0, out_valid, in_ready, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && done === 1'b0, "R1 idle after reset",
          {62'd0, out_valid, done}, 64'd0);
    // single-bit vector, all densities
    run_case(0, 0, 2'b00, 2'b00, 11, 1, 0, 0, "R2 bit vec x1");
    run_case(0, 0, 2'b01, 2'b00, 11, 2, 0, 0, "R2 bit vec x2");
    run_case(0, 0, 2'b10, 2'b00, 11, 3, 1, 0, "R2 bit vec x4");
    run_case(0, 0, 2'b11, 2'b00, 20, 4, 0, 0, "R2 bit vec x8");
    // single-bit scalar
    run_case(0, 1, 2'b00, 2'b00, 64, 5, 0, 0, "R4 bit scalar full");
    run_case(0, 1, 2'b10, 2'b01, 37, 6, 1, 0, "R4 bit scalar partial");
    // nibble vector, destination caps
    run_case(1, 0, 2'b00, 2'b00, 5, 7, 0, 0, "R5 nib w64 x1");
    run_case(1, 0, 2'b01, 2'b00, 7, 8, 0, 0, "R5 nib w64 x2");
    run_case(1, 0, 2'b10, 2'b00, 10, 9, 0, 0, "R5 nib w64 x4");
    run_case(1, 0, 2'b11, 2'b00, 17, 10, 1, 0, "R5 nib w64 x8");
    run_case(1, 0, 2'b11, 2'b01, 10, 11, 0, 0, "R5 nib w8 capped x4");
    run_case(1, 0, 2'b10, 2'b10, 9, 12, 0, 0, "R5 nib w16 x4");
    run_case(1, 0, 2'b11, 2'b11, 16, 13, 0, 0, "R5 nib w32 x8");
    // nibble scalar
    run_case(1, 1, 2'b00, 2'b00, 16, 14, 0, 0, "R6 nib scalar full");
    run_case(1, 1, 2'b11, 2'b11, 5, 15, 1, 0, "R6 nib scalar partial");
    // start during a run is ignored
    run_case(0, 0, 2'b01, 2'b00, 9, 16, 0, 1, "R10 start while busy");
    run_case(1, 0, 2'b01, 2'b00, 1, 17, 0, 0, "R7 single result");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule